// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block holds one 32-bit control/status word on a simple word-wide register port. The word records why the system last came out of reset, and it lets software ask for a soft reset. Only the five most significant bits hold state. Three of them are status flags that software clears by writing ones. The other two are request flags that software sets by writing ones.

When software writes a one to either request flag, the block raises `rst_req` for a single clock cycle. A reset sequencer outside this block acts on that pulse and later drives `sys_reset`. A small saturating counter tallies reset events since the counter was last zeroed. The first reset event after the counter reaches zero replaces the whole word with the power-on flag alone. Later events leave the word as it is.

A small state machine tracks the reset input. It has three states:
- `ST_COLD`: after hardware power-up, before any reset event has been seen.
- `ST_HELD`: the reset input is asserted.
- `ST_RUN`: normal operation after a reset has been released.

It has four transitions:
- COLD→HELD and RUN→HELD when `sys_reset` rises.
- HELD→RUN when `sys_reset` falls.
- HELD→HELD while `sys_reset` stays high.

The reset event fires on entry to HELD. Register writes are accepted only while `sys_reset` is low.

Top module: `rstcsr_top`

## Requirements
- R1: While `pwr_up_n` is low, the word, the counter and `rst_req` are all zero, and a read of the word returns 0x00000000.
- R2: The word is read and written at byte addresses 0xF024–0xF027, where address bits 1:0 are ignored. Addresses 0xF020–0xF023 and every other address read as zero, and writes to them change nothing.
- R3: Write data bits 26:0 are discarded, and the word always reads zero in bits 26:0.
- R4: Bits 31 (power-on flag), 28 and 27 (button status flags) clear when a one is written to them. Writing a zero to them leaves them unchanged. Nothing in this block sets bits 28 or 27.
- R5: Bits 30 (soft power-on request) and 29 (soft external reset request) are set by writing a one. Writing a zero leaves them unchanged. A write to the word that sets bit 30 or bit 29 produces a pulse on `rst_req` in the cycle after the write. Back-to-back such writes give back-to-back pulses.
- R6: A write with bit 30 set zeroes the reset counter, so the next reset event loads the power-on value.
- R7: A write with bit 29 set and bit 30 clear requests a reset but leaves the counter unchanged.
- R8: On a reset event, if the counter is zero the word becomes exactly 0x80000000; otherwise the word is unchanged. The counter then increments.
- R9: The counter saturates at 2^CNT_W−1 and never wraps to zero, so any number of reset events never reproduces the power-on value without a bit-30 write.
- R10: A reset event is the first cycle in which `sys_reset` is high; holding it high counts as one event. While `sys_reset` is high, writes are ignored and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_up_n | input | 1 | Hardware power-up, active low, asynchronous; clears all state |
| sys_reset | input | 1 | System reset from the sequencer, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W (16) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle soft reset request pulse |

## Verification
A behavioural reference model of the word and counter is compared against `rdata` and `rst_req` on every clock.

The stimulus includes:
- Writes of all-zero, all-ones-in-the-low-bits and mixed patterns. These separate the clear-on-one bits from the set-on-one bits and from the discarded bits.
- Reads and writes at the lower word of the slot, at a non-zero byte lane of the upper word, and at a foreign address. These separate correct decode from decode on the wrong bits.
- Single-cycle and multi-cycle reset pulses, and writes made during reset. These separate edge-counted events from level-counted ones.
- A long run of resets followed by a bit-29 write and a bit-30 write. This separates a saturating counter from a wrapping one, and separates the two request kinds by their effect on the next power-on load.

// File: rtl/rstcsr_pkg.sv
package rstcsr_pkg;

    typedef enum logic [1:0] {
        ST_COLD = 2'd0,
        ST_HELD = 2'd1,
        ST_RUN  = 2'd2
    } rst_state_e;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned TOP_LSB  = 27;
    localparam int unsigned STORE_W  = DATA_W - TOP_LSB;

    localparam int unsigned POS_POR  = 31;
    localparam int unsigned POS_SPOR = 30;
    localparam int unsigned POS_SXIR = 29;

    localparam logic [DATA_W-1:0] W1C_MASK = 32'h9800_0000;
    localparam logic [DATA_W-1:0] W1S_MASK = 32'h6000_0000;
    localparam logic [DATA_W-1:0] POR_VAL  = 32'h8000_0000;

endpackage

// File: rtl/rstcsr_decode.sv
module rstcsr_decode #(
    parameter int unsigned         ADDR_W  = 16,
    parameter logic [ADDR_W-1:0]   WORD_AD = 16'hF024
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LANE_BITS = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] SEL_MASK  = ~LANE_BITS;

    always_comb begin
        hit = (((addr ^ WORD_AD) & SEL_MASK) == '0);
    end
endmodule

// File: rtl/rstcsr_cnt.sv
module rstcsr_cnt #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             pwr_up_n,
    input  logic             inc,
    input  logic             clr,
    output logic             zero,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge pwr_up_n) begin
        if (!pwr_up_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        zero = (cnt == '0);
    end

    // R9: a changed count either advanced by one or was cleared
    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));

    // R9: a saturated count stays saturated unless cleared
    assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!pwr_up_n)
        ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/rstcsr_fsm.sv
module rstcsr_fsm
    import rstcsr_pkg::*;
(
    input  logic clk,
    input  logic pwr_up_n,
    input  logic sys_reset,
    output logic evt,
    output logic acc_ok
);
    rst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge pwr_up_n) begin
        if (!pwr_up_n) begin
            state_q <= ST_COLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD: if (sys_reset)  state_d = ST_HELD;
            ST_HELD: if (!sys_reset) state_d = ST_RUN;
            ST_RUN:  if (sys_reset)  state_d = ST_HELD;
            default: state_d = ST_COLD;
        endcase
    end

    always_comb begin
        evt    = 1'b0;
        acc_ok = 1'b0;
        unique case (state_q)
            ST_COLD, ST_RUN: begin
                evt    = sys_reset;
                acc_ok = !sys_reset;
            end
            ST_HELD: begin
                evt    = 1'b0;
                acc_ok = !sys_reset;
            end
            default: begin
                evt    = 1'b0;
                acc_ok = 1'b0;
            end
        endcase
    end

    // R10: a held reset input yields one event only
    assert_evt_single_R10: assert property (@(posedge clk) disable iff (!pwr_up_n)
        evt |=> !evt);

    // R10: no access is accepted while the reset input is high
    assert_no_acc_in_reset_R10: assert property (@(posedge clk) disable iff (!pwr_up_n)
        sys_reset |-> !acc_ok);
endmodule

// File: rtl/rstcsr_top.sv
module rstcsr_top
    import rstcsr_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] WORD_AD = 16'hF024,
    parameter int unsigned       CNT_W   = 4
) (
    input  logic              clk,
    input  logic              pwr_up_n,
    input  logic              sys_reset,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    localparam logic [DATA_W-1:0] REQ_MASK = W1S_MASK;
    localparam int unsigned       SPOR_IX  = POS_SPOR - TOP_LSB;
    localparam int unsigned       POR_IX   = POS_POR - TOP_LSB;

    logic               hit;
    logic               evt;
    logic               acc_ok;
    logic               wr_go;
    logic               cnt_zero;
    logic [CNT_W-1:0]   cnt;
    logic [STORE_W-1:0] csr_q;
    logic               req_bits;
    logic               spor_bit;

    rstcsr_decode #(
        .ADDR_W  (ADDR_W),
        .WORD_AD (WORD_AD)
    ) u_decode (
        .addr (addr),
        .hit  (hit)
    );

    rstcsr_fsm u_fsm (
        .clk       (clk),
        .pwr_up_n  (pwr_up_n),
        .sys_reset (sys_reset),
        .evt       (evt),
        .acc_ok    (acc_ok)
    );

    always_comb begin
        wr_go    = wr_en && hit && acc_ok;
        req_bits = |(wdata & REQ_MASK);
        spor_bit = wdata[POS_SPOR];
    end

    rstcsr_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .pwr_up_n (pwr_up_n),
        .inc      (evt),
        .clr      (wr_go && spor_bit),
        .zero     (cnt_zero),
        .cnt      (cnt)
    );

    for (genvar b = 0; b < STORE_W; b++) begin : g_bit
        localparam int unsigned POS = TOP_LSB + b;
        logic nxt;
        if (W1C_MASK[POS]) begin : g_w1c
            always_comb nxt = csr_q[b] & ~(wr_go & wdata[POS]);
        end else begin : g_w1s
            always_comb nxt = csr_q[b] | (wr_go & wdata[POS]);
        end
        always_ff @(posedge clk or negedge pwr_up_n) begin
            if (!pwr_up_n) begin
                csr_q[b] <= 1'b0;
            end else if (evt && cnt_zero) begin
                csr_q[b] <= POR_VAL[POS];
            end else begin
                csr_q[b] <= nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge pwr_up_n) begin
        if (!pwr_up_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= wr_go && req_bits;
        end
    end

    always_comb begin
        rdata = hit ? {csr_q, {TOP_LSB{1'b0}}} : '0;
    end

    // R8: first event with a zero count loads the power-on value alone
    assert_por_load_R8: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (evt && cnt_zero) |=> (csr_q == STORE_W'(1) << POR_IX));

    // R8: an event with a non-zero count keeps the stored bits
    assert_por_keep_R8: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (evt && !cnt_zero) |=> $stable(csr_q));

    // R10: the word is frozen and requests are quiet while reset is held
    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (sys_reset && !evt) |=> $stable(csr_q));
    assert_req_quiet_R10: assert property (@(posedge clk) disable iff (!pwr_up_n)
        sys_reset |=> !rst_req);

    // R6: a soft power-on write leaves the counter at zero
    assert_spor_clears_R6: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (wr_go && spor_bit) |=> (cnt_zero && csr_q[SPOR_IX]));

    // R4: writing one to the power-on flag clears it
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (wr_go && wdata[POS_POR] && !evt) |=> !csr_q[POR_IX]);
endmodule

// File: tb/test_rstcsr_top.sv
module test_rstcsr_top;
    localparam int ADDR_W = 16;
    localparam int CNT_MAXV = 15;

    logic        clk = 1'b0;
    logic        pwr_up_n;
    logic        sys_reset;
    logic        wr_en;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_word;
    int          m_cnt;
    bit          m_held;
    bit          m_req;

    always #2 clk = ~clk;

    rstcsr_top #(.ADDR_W(ADDR_W)) i_rstcsr_top (
        .clk       (clk),
        .pwr_up_n  (pwr_up_n),
        .sys_reset (sys_reset),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rst_req   (rst_req)
    );

    function automatic bit on_word(input logic [15:0] a);
        return (a >> 2) == (16'hF024 >> 2);
    endfunction

    task automatic model_step();
        logic [31:0] v;
        m_req = 0;
        if (!pwr_up_n) begin
            m_word = 0; m_cnt = 0; m_held = 0;
        end else if (sys_reset) begin
            if (!m_held) begin
                if (m_cnt == 0) m_word = 32'h8000_0000;
                if (m_cnt < CNT_MAXV) m_cnt++;
            end
            m_held = 1;
        end else begin
            m_held = 0;
            if (wr_en && on_word(addr)) begin
                v = wdata & 32'hF800_0000;
                m_word = (m_word & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
                if (v[30]) begin m_cnt = 0; m_req = 1; end
                else if (v[29]) m_req = 1;
            end
        end
    endtask

    task automatic tick(input string tag);
        logic [31:0] exp_rd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp_rd = on_word(addr) ? m_word : 32'h0;
        total++;
        if (rdata !== exp_rd) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
        end
        total++;
        if (rst_req !== m_req) begin
            bad++;
            $display("FAIL %s rst_req actual=%b expected=%b", tag, rst_req, m_req);
        end
    endtask

    task automatic idle(input logic [15:0] a);
        wr_en = 0; addr = a; wdata = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        wr_en = 1; addr = a; wdata = d;
        tick(tag);
        idle(16'hF024);
        tick(tag);
    endtask

    task automatic pulse_reset(input int n, input string tag);
        sys_reset = 1;
        for (int i = 0; i < n; i++) tick(tag);
        sys_reset = 0;
        tick(tag);
    endtask

    initial begin
        pwr_up_n = 0; sys_reset = 0;
        idle(16'hF024);
        tick("R1"); tick("R1");
        pwr_up_n = 1;
        tick("R1");
        // first reset loads the power-on flag
        pulse_reset(1, "R8");
        // decode checks
        idle(16'hF020); tick("R2");
        idle(16'hF026); tick("R2");
        idle(16'h0024); tick("R2");
        wr(16'hF020, 32'hFFFF_FFFF, "R2");
        wr(16'h1024, 32'hFFFF_FFFF, "R2");
        // zero write keeps status, low bits discarded
        wr(16'hF024, 32'h0000_0000, "R4");
        wr(16'hF024, 32'h07FF_FFFF, "R3");
        wr(16'hF024, 32'h9800_0000, "R4");
        // soft external request, counter untouched
        wr(16'hF027, 32'h2000_0000, "R7");
        pulse_reset(3, "R8");
        // write during reset ignored
        sys_reset = 1; wr_en = 1; addr = 16'hF024; wdata = 32'h4000_0000;
        tick("R10"); tick("R10");
        sys_reset = 0; idle(16'hF024); tick("R10");
        // soft power-on request zeroes the counter
        wr(16'hF024, 32'h4000_0000, "R6");
        pulse_reset(1, "R6");
        // back-to-back requests, sticky bits
        wr_en = 1; addr = 16'hF024; wdata = 32'h6000_0000;
        tick("R5"); tick("R5");
        idle(16'hF024); tick("R5");
        wr(16'hF024, 32'h0000_0000, "R5");
        // saturation: many resets must not wrap into a power-on load
        wr(16'hF024, 32'h8000_0000, "R4");
        for (int k = 0; k < 20; k++) pulse_reset(1, "R9");
        wr(16'hF024, 32'h2000_0000, "R9");
        pulse_reset(2, "R9");
        wr(16'hF024, 32'h4000_0000, "R6");
        pulse_reset(1, "R8");
        // power-up in mid operation
        pwr_up_n = 0; tick("R1");
        idle(16'hF020); tick("R1");
        pwr_up_n = 1; idle(16'hF024); tick("R1");
        pulse_reset(1, "R8");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule